// File: doc/BRIEF.md
# Serial Audio Stereo Capture Channel

This block receives one stereo stream on a three-wire serial audio link as a slave. The bit clock, word select and data lines come from an external source. They are oversampled in the faster system clock domain, and the bit clock passes through a glitch filter whose strength can be selected. Left and right samples of 16, 24 or 32 bits are assembled and formatted into 32-bit words. The words go into a small receive FIFO, which a bus-side reader drains one word at a time.

Static configuration pins select the framing and the polarity. Framing is either I2S-style, where the MSB follows the word-select change by one bit, or left-justified. Polarity covers the bit-clock sampling edge and the word-select level that marks the left channel. Further pins select the sample width, 16-bit pair packing, top alignment of 24-bit samples and the bit-clock filter mode. A flush pulse empties the FIFO and clears the sticky overflow flag. Capture is gated by an enable and always begins on a whole frame.

Top module: `i2s_rx_capture`

## Requirements
- R1: With `i2s_mode_i`=0, the sample MSB is the bit sampled on the same bit-clock edge that first sees the new word-select level.
- R2: With `i2s_mode_i`=1, the sample MSB is the bit sampled on the edge after the one that first sees the new word-select level.
- R3: `sck_inv_i`=0 samples on the rising bit-clock edge and `sck_inv_i`=1 samples on the falling edge.
- R4: `left_low_i`=1 marks word select low as left and `left_low_i`=0 marks it high as left. The left word of a frame enters the FIFO before the right word.
- R5: `sample_fmt_i`=2 (32-bit, 32-clock slot) stores the 32 slot bits unchanged, first bit at bit 31.
- R6: `sample_fmt_i`=1 (24-bit, 32-clock slot) keeps the first 24 slot bits. With `pack_hi_i`=0 they are stored as {8'h00, s[23:0]}. With `pack_hi_i`=1 they are stored as {s[23:0], 8'h00}.
- R7: `sample_fmt_i`=0 (16-bit, 16-clock slot) stores {16'h0000, s} when `pack16_i`=0. When `pack16_i`=1 it stores one word {left, right} per frame, with left in bits 31:16.
- R8: `filt_en_i`=0 accepts a bit-clock level after 1 synchronised sample, which needs a system clock of at least 6x the bit clock. `filt_en_i`=1 with `filt_mode_i`=1 needs 2 equal samples, and with `filt_mode_i`=0 needs 3. In both filtered modes a one-cycle bit-clock glitch is ignored.
- R9: No word is written while `en_i`=0. After `en_i` rises, capture starts with the first left slot that begins afterwards, and any frame already under way is dropped.
- R10: The FIFO is show-ahead. `rd_valid_o` is high while it holds data, `rd_data_o` shows the oldest word, `rd_en_i` pops it, and `level_o` gives the occupancy.
- R11: A word that arrives while the FIFO is full is dropped, the stored words are kept, and `ovf_o` goes high and stays high.
- R12: A cycle with `flush_i`=1 empties the FIFO and clears `ovf_o`, both visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word select |
| sd_i | input | 1 | Serial data |
| en_i | input | 1 | Capture enable |
| i2s_mode_i | input | 1 | 1: MSB one bit after word-select change; 0: left-justified |
| sck_inv_i | input | 1 | 1: sample on falling bit-clock edge |
| left_low_i | input | 1 | 1: word select low means left |
| sample_fmt_i | input | 2 | 0: 16-bit, 1: 24-bit, 2: 32-bit |
| pack16_i | input | 1 | Pack a 16-bit left/right pair in one word |
| pack_hi_i | input | 1 | Top-align 24-bit samples |
| filt_en_i | input | 1 | Bit-clock glitch filter enable |
| filt_mode_i | input | 1 | 0: 3-sample hold, 1: 2-sample hold |
| flush_i | input | 1 | Empty FIFO and clear overflow |
| rd_en_i | input | 1 | Pop the head word |
| rd_data_o | output | 32 | Head word of the FIFO |
| rd_valid_o | output | 1 | FIFO not empty |
| level_o | output | 4 | Words held in the FIFO |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A sample word reaches the FIFO a few system clocks after the bit-clock edge that carries its last bit. The path is two synchroniser flops, up to two filter taps, the edge register, the push register and the FIFO write. The scoreboard therefore never pins that delay. It compares words in arrival order and confirms that every expected word has arrived only after idle bit periods and a margin of system clocks. The flush and overflow effects follow their cause by exactly one system clock, so those checks are sampled at the falling edge right after the triggering cycle.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  typedef enum logic [1:0] {
    FMT_16 = 2'd0,
    FMT_24 = 2'd1,
    FMT_32 = 2'd2
  } smp_fmt_e;
endpackage

// File: rtl/i2s_rx_sampler.sv
module i2s_rx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  input  logic sck_inv_i,
  input  logic filt_en_i,
  input  logic filt_mode_i,
  output logic bit_stb_o,
  output logic ws_o,
  output logic sd_o
);
  localparam int NSIG = 3;
  localparam int LEN  = SYNC_STAGES + 2;
  localparam int T0   = SYNC_STAGES - 1;

  logic [NSIG-1:0][LEN-1:0] chain_q;
  logic [NSIG-1:0] raw, tap0, tap1, tap2;
  logic lvl_q, act_lvl;
  logic hold1, hold2, hold3, accept;

  assign raw = {sd_i, ws_i, sck_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else begin
      for (int s = 0; s < NSIG; s++)
        chain_q[s] <= {chain_q[s][LEN-2:0], raw[s]};
    end
  end

  for (genvar g = 0; g < NSIG; g++) begin : g_tap
    assign tap0[g] = chain_q[g][T0];
    assign tap1[g] = chain_q[g][T0+1];
    assign tap2[g] = chain_q[g][T0+2];
  end

  assign act_lvl = ~sck_inv_i;
  assign hold1   = tap0[0] != lvl_q;
  assign hold2   = hold1 && (tap0[0] == tap1[0]);
  assign hold3   = hold2 && (tap1[0] == tap2[0]);
  assign accept  = !filt_en_i ? hold1 : (filt_mode_i ? hold2 : hold3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q     <= 1'b0;
      bit_stb_o <= 1'b0;
      ws_o      <= 1'b0;
      sd_o      <= 1'b0;
    end else begin
      bit_stb_o <= accept && (tap0[0] == act_lvl);
      if (accept) begin
        lvl_q <= tap0[0];
        // take word select and data from the tap aligned with the first new bit-clock sample
        if (!filt_en_i) begin
          ws_o <= tap0[1]; sd_o <= tap0[2];
        end else if (filt_mode_i) begin
          ws_o <= tap1[1]; sd_o <= tap1[2];
        end else begin
          ws_o <= tap2[1]; sd_o <= tap2[2];
        end
      end
    end
  end

  // R8
  stb_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |=> !bit_stb_o);
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
  import i2s_rx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          stb_i,
  input  logic          ws_i,
  input  logic          sd_i,
  input  logic          i2s_mode_i,
  input  logic          left_low_i,
  input  smp_fmt_e      fmt_i,
  input  logic          pack16_i,
  input  logic          pack_hi_i,
  output logic          push_o,
  output logic [DW-1:0] data_o
);
  localparam int HW  = DW / 2;
  localparam int PAD = DW - 24;
  localparam int CW  = $clog2(DW + 1);

  logic [DW-1:0] sr_q, sr_n, word_n;
  logic [HW-1:0] hold_q;
  logic [CW-1:0] cnt_q, cnt_n, slot_w;
  logic ws_q, ws_vld_q, start_dly_q, act_q, armed_q, cap_q, left_q, pair_q;
  logic is_left, trans, start, act_n, done, armed_n, cap_n, left_n;

  assign slot_w  = (fmt_i == FMT_16) ? CW'(HW) : CW'(DW);
  assign is_left = left_low_i ? ~ws_i : ws_i;
  assign trans   = ws_vld_q && (ws_i != ws_q);
  assign start   = i2s_mode_i ? start_dly_q : trans;
  assign sr_n    = start ? {{(DW-1){1'b0}}, sd_i} : {sr_q[DW-2:0], sd_i};
  assign cnt_n   = start ? CW'(1) : cnt_q + CW'(1);
  assign act_n   = start | act_q;
  assign done    = act_n && (cnt_n == slot_w);
  assign armed_n = en_i && (armed_q || (start && is_left));
  assign cap_n   = start ? armed_n : cap_q;
  assign left_n  = start ? is_left : left_q;

  always_comb begin
    case (fmt_i)
      FMT_16:  word_n = {{HW{1'b0}}, sr_n[HW-1:0]};
      FMT_24:  word_n = pack_hi_i ? {sr_n[DW-1:PAD], {PAD{1'b0}}}
                                  : {{PAD{1'b0}}, sr_n[DW-1:PAD]};
      default: word_n = sr_n;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0; hold_q <= '0; cnt_q <= '0;
      ws_q <= 1'b0; ws_vld_q <= 1'b0; start_dly_q <= 1'b0;
      act_q <= 1'b0; armed_q <= 1'b0; cap_q <= 1'b0; left_q <= 1'b0; pair_q <= 1'b0;
      push_o <= 1'b0; data_o <= '0;
    end else begin
      push_o <= 1'b0;
      if (!en_i) begin
        armed_q <= 1'b0;
        pair_q  <= 1'b0;
      end
      if (stb_i) begin
        ws_q        <= ws_i;
        ws_vld_q    <= 1'b1;
        start_dly_q <= trans;
        sr_q        <= sr_n;
        if (act_n) cnt_q <= cnt_n;
        act_q       <= act_n && !done;
        armed_q     <= armed_n;
        cap_q       <= cap_n;
        left_q      <= left_n;
        if (done && cap_n && en_i) begin
          if (fmt_i == FMT_16 && pack16_i) begin
            if (left_n) begin
              hold_q <= sr_n[HW-1:0];
              pair_q <= 1'b1;
            end else if (pair_q) begin
              push_o <= 1'b1;
              data_o <= {hold_q, sr_n[HW-1:0]};
              pair_q <= 1'b0;
            end
          end else begin
            push_o <= 1'b1;
            data_o <= word_n;
          end
        end
      end
    end
  end

  // R9
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !push_o);
  // R9
  push_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> !push_o);
endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [DW-1:0]              data_i,
  input  logic                       pop_i,
  input  logic                       flush_i,
  output logic [DW-1:0]              rd_data_o,
  output logic                       rd_valid_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] cnt_q;
  logic full, empty, do_wr, do_rd;

  assign full   = cnt_q == LW'(DEPTH);
  assign empty  = cnt_q == '0;
  assign do_wr  = push_i && !full && !flush_i;
  assign do_rd  = pop_i && !empty && !flush_i;

  assign rd_data_o  = mem_q[rd_ptr_q];
  assign rd_valid_o = !empty;
  assign level_o    = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0; rd_ptr_q <= '0; cnt_q <= '0; ovf_o <= 1'b0;
    end else if (flush_i) begin
      wr_ptr_q <= '0; rd_ptr_q <= '0; cnt_q <= '0; ovf_o <= 1'b0;
    end else begin
      if (do_wr) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_rd) rd_ptr_q <= nxt(rd_ptr_q);
      if (do_wr && !do_rd) cnt_q <= cnt_q + LW'(1);
      else if (do_rd && !do_wr) cnt_q <= cnt_q - LW'(1);
      if (push_i && full) ovf_o <= 1'b1;
    end
  end

  // R10
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));
  // R10
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && rd_valid_o && !push_i && !flush_i) |=> level_o == $past(level_o) - LW'(1));
  // R11
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && level_o == LW'(DEPTH) && !flush_i) |=> ovf_o);
  // R11
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !flush_i) |=> ovf_o);
  // R12
  flush_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!rd_valid_o && !ovf_o));
endmodule

// File: rtl/i2s_rx_capture.sv
module i2s_rx_capture
  import i2s_rx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            sck_i,
  input  logic                            ws_i,
  input  logic                            sd_i,
  input  logic                            en_i,
  input  logic                            i2s_mode_i,
  input  logic                            sck_inv_i,
  input  logic                            left_low_i,
  input  logic [1:0]                      sample_fmt_i,
  input  logic                            pack16_i,
  input  logic                            pack_hi_i,
  input  logic                            filt_en_i,
  input  logic                            filt_mode_i,
  input  logic                            flush_i,
  input  logic                            rd_en_i,
  output logic [DATA_W-1:0]               rd_data_o,
  output logic                            rd_valid_o,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] level_o,
  output logic                            ovf_o
);
  logic bit_stb, ws_s, sd_s, push;
  logic [DATA_W-1:0] push_data;
  smp_fmt_e fmt;

  assign fmt = smp_fmt_e'(sample_fmt_i);

  i2s_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i, .rst_ni, .sck_i, .ws_i, .sd_i,
    .sck_inv_i, .filt_en_i, .filt_mode_i,
    .bit_stb_o(bit_stb), .ws_o(ws_s), .sd_o(sd_s)
  );

  i2s_rx_deser #(.DW(DATA_W)) u_deser (
    .clk_i, .rst_ni, .en_i,
    .stb_i(bit_stb), .ws_i(ws_s), .sd_i(sd_s),
    .i2s_mode_i, .left_low_i, .fmt_i(fmt), .pack16_i, .pack_hi_i,
    .push_o(push), .data_o(push_data)
  );

  i2s_rx_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .data_i(push_data), .pop_i(rd_en_i), .flush_i,
    .rd_data_o, .rd_valid_o, .level_o, .ovf_o
  );
endmodule

// File: tb/i2s_rx_capture_bench.sv
module i2s_rx_capture_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic en_i = 1'b0, i2s_mode_i = 1'b0, sck_inv_i = 1'b0, left_low_i = 1'b0;
  logic [1:0] sample_fmt_i = 2'd2;
  logic pack16_i = 1'b0, pack_hi_i = 1'b0, filt_en_i = 1'b1, filt_mode_i = 1'b0;
  logic flush_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic rd_valid_o, ovf_o;
  logic [3:0] level_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0, drain = 1, glitch = 0;
  int slot_w = 32, half = 4;
  logic prev_sd = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  i2s_rx_capture u_i2s_rx_capture (
    .clk_i(clk), .rst_ni, .sck_i, .ws_i, .sd_i, .en_i, .i2s_mode_i, .sck_inv_i,
    .left_low_i, .sample_fmt_i, .pack16_i, .pack_hi_i, .filt_en_i, .filt_mode_i,
    .flush_i, .rd_en_i, .rd_data_o, .rd_valid_o, .level_o, .ovf_o
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_w(input logic [31:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    rd_en_i = 1'b0;
    if (rst_ni && drain && rd_valid_o) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected word", rd_data_o, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data_o == e, t, rd_data_o, e);
      end
      rd_en_i = 1'b1;
    end
  end

  task automatic period(input logic ws, input logic b);
    logic o;
    o = i2s_mode_i ? prev_sd : b;
    prev_sd = b;
    sck_i = sck_inv_i; ws_i = ws; sd_i = o;
    if (glitch) begin
      @(negedge clk); sck_i = ~sck_inv_i;
      @(negedge clk); sck_i = sck_inv_i;
      repeat (half - 2) @(negedge clk);
    end else repeat (half) @(negedge clk);
    sck_i = ~sck_inv_i;
    repeat (half) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) period(left_low_i, 1'b0);
  endtask

  task automatic send_frame(input logic [31:0] l, input logic [31:0] r, input bit en_mid);
    for (int i = 0; i < slot_w; i++) period(~left_low_i, l[31-i]);
    if (en_mid) en_i = 1'b1;
    for (int i = 0; i < slot_w; i++) period(left_low_i, r[31-i]);
  endtask

  function automatic logic [31:0] fmt_word(input logic [31:0] s);
    case (sample_fmt_i)
      2'd0: return {16'h0, s[31:16]};
      2'd1: return pack_hi_i ? {s[31:8], 8'h0} : {8'h0, s[31:8]};
      default: return s;
    endcase
  endfunction

  task automatic run_pairs(input int n, input logic [31:0] seed, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [31:0] l, r;
      l = seed ^ (32'h9E37_79B9 * (k + 1));
      r = ~seed ^ (32'h7F4A_7C15 * (k + 3));
      if (sample_fmt_i == 2'd0 && pack16_i) expect_w({l[31:16], r[31:16]}, tag);
      else begin
        expect_w(fmt_word(l), tag);
        expect_w(fmt_word(r), tag);
      end
      send_frame(l, r, 1'b0);
    end
  endtask

  task automatic settle(input string tag);
    idle(2);
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic setup(input bit i2s, input bit inv, input bit llow, input logic [1:0] fmt,
                       input bit p16, input bit phi, input bit fen, input bit fmode, input int h);
    en_i = 1'b0;
    i2s_mode_i = i2s; sck_inv_i = inv; left_low_i = llow; sample_fmt_i = fmt;
    pack16_i = p16; pack_hi_i = phi; filt_en_i = fen; filt_mode_i = fmode; half = h;
    slot_w = (fmt == 2'd0) ? 16 : 32;
    idle(2);
    en_i = 1'b1;
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!rd_valid_o && level_o == 0 && !ovf_o, "R10 reset", {rd_valid_o, level_o, ovf_o}, 0);

    // R1 R5 left-justified 32-bit, left on word select high
    setup(0, 0, 0, 2'd2, 0, 0, 1, 0, 4);
    run_pairs(3, 32'hA5C3_0F81, "R1/R5 lj 32-bit");
    settle("R1 words complete");

    // R2 R4 I2S framing, left on word select low
    setup(1, 0, 1, 2'd2, 0, 0, 1, 0, 4);
    run_pairs(3, 32'h1234_5678, "R2/R4 i2s 32-bit");
    settle("R2 words complete");

    // R3 falling-edge sampling
    setup(1, 1, 1, 2'd2, 0, 0, 1, 0, 4);
    run_pairs(2, 32'hDEAD_BEEF, "R3 inverted bit clock");
    settle("R3 words complete");

    // R6 24-bit right- and top-aligned
    setup(1, 0, 1, 2'd1, 0, 0, 1, 0, 4);
    run_pairs(2, 32'h8765_4321, "R6 24-bit low aligned");
    settle("R6 low words complete");
    setup(1, 0, 1, 2'd1, 0, 1, 1, 0, 4);
    run_pairs(2, 32'h0F1E_2D3C, "R6 24-bit top aligned");
    settle("R6 top words complete");

    // R7 16-bit unpacked and packed
    setup(0, 0, 0, 2'd0, 0, 0, 1, 0, 4);
    run_pairs(2, 32'hC0DE_F00D, "R7 16-bit unpacked");
    settle("R7 unpacked complete");
    setup(1, 0, 1, 2'd0, 1, 0, 1, 0, 4);
    run_pairs(3, 32'h55AA_33CC, "R7 16-bit packed");
    settle("R7 packed complete");

    // R8 glitch rejection in both filter modes, then unfiltered at 6x
    setup(1, 0, 1, 2'd2, 0, 0, 1, 1, 5);
    glitch = 1;
    run_pairs(2, 32'h3141_5926, "R8 mode1 glitch");
    settle("R8 mode1 complete");
    setup(1, 0, 1, 2'd2, 0, 0, 1, 0, 5);
    glitch = 1;
    run_pairs(2, 32'h2718_2818, "R8 mode0 glitch");
    settle("R8 mode0 complete");
    glitch = 0;
    setup(0, 0, 0, 2'd2, 0, 0, 0, 0, 3);
    run_pairs(2, 32'h6A09_E667, "R8 unfiltered 6x");
    settle("R8 unfiltered complete");

    // R9 disabled: nothing written
    setup(1, 0, 1, 2'd2, 0, 0, 1, 0, 4);
    en_i = 1'b0;
    send_frame(32'h1111_1111, 32'h2222_2222, 1'b0);
    idle(2);
    repeat (12) @(negedge clk);
    check(level_o == 0 && !rd_valid_o, "R9 disabled no words", level_o, 0);
    // R9 enable mid-frame: partial frame dropped, next frame captured
    send_frame(32'h3333_3333, 32'h4444_4444, 1'b1);
    expect_w(32'h5555_AAAA, "R9 first whole frame left");
    expect_w(32'hAAAA_5555, "R9 first whole frame right");
    send_frame(32'h5555_AAAA, 32'hAAAA_5555, 1'b0);
    settle("R9 words complete");

    // R10 R11 overflow: 10 words into 8 entries
    drain = 0;
    for (int k = 0; k < 5; k++) send_frame(32'hF000_0000 + k * 2, 32'hF000_0001 + k * 2, 1'b0);
    idle(2);
    repeat (12) @(negedge clk);
    check(level_o == 8, "R10 level full", level_o, 8);
    check(rd_data_o == 32'hF000_0000, "R10 head is oldest", rd_data_o, 32'hF000_0000);
    check(ovf_o == 1'b1, "R11 overflow set", ovf_o, 1);
    repeat (5) @(negedge clk);
    check(ovf_o == 1'b1 && level_o == 8, "R11 overflow sticky", {ovf_o, level_o}, {1'b1, 4'd8});
    // R12 flush
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    check(!rd_valid_o && level_o == 0, "R12 flush empties", level_o, 0);
    check(!ovf_o, "R12 flush clears overflow", ovf_o, 0);
    drain = 1;
    run_pairs(1, 32'h0BAD_CAFE, "R12 capture after flush");
    settle("R12 words complete");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule